// File: doc/BRIEF.md
# Banked GPIO Register Controller

This block is a memory-mapped general-purpose I/O controller for a parameterised number of pins (144 by default). Pins are grouped in banks of 32, and each bank has a small register set reached over a simple synchronous bus: one access per cycle, with an address, a write enable and write data, and read data returned in the next cycle. For each pin the controller holds a direction bit and an output latch. It drives the pin-side output data and output-enable vectors from those registers. It also samples the pin-side input vector through a two-flop synchronizer.

Software changes outputs in one of two ways. It can load the whole output latch of a bank. It can also write a mask to a set port or a clear port, which raises or lowers only the selected bits without a read-modify-write. The input word of a bank returns the synchronized pin level whether the pin is configured as an input or an output. The synchronizer adds latency, so a read issued right after a pin changes still returns the old level.

Top module: `gpio_banked`

## Requirements
- R1: During and after synchronous reset every direction bit is 1, every output latch bit is 0, `pin_oe` and `pin_out` are all zero and `rd_data` is zero.
- R2: Bank b occupies the five aligned words starting at byte address 0x10 + 0x28*b. The word offsets are: +0x0 direction, +0x4 output latch, +0x8 set port, +0xC clear port, +0x10 input level. Bank b holds pins 32*b to 32*b+31, and bit i of a word is pin 32*b+i.
- R3: A direction bit of 1 makes its pin an input (`pin_oe` bit 0). A 0 makes it an output (`pin_oe` bit 1). A write to a direction word takes effect on `pin_oe` right after the clock edge that accepts it, and the direction word reads back the written value.
- R4: A write to the output-latch word replaces the whole latch. `pin_out` follows the latch right after the accepting edge, whatever the direction.
- R5: Writing the set port raises each latch bit whose write-data bit is 1 and leaves the bits written as 0 unchanged.
- R6: Writing the clear port lowers each latch bit whose write-data bit is 1 and leaves the bits written as 0 unchanged.
- R7: A read of the set port or the clear port returns the current output latch.
- R8: The input word returns the pin level through two synchronizing flops. A pin change first captured at clock edge k reaches `rd_data` no earlier than edge k+2, and an output pin's own level is readable.
- R9: A read of any unmapped or unaligned address returns zero. Writes to such addresses, and writes to an input-level word, change no register and no output.
- R10: In a bank that is only partly populated, bits above the last real pin read as zero in every word and ignore writes.
- R11: Accesses take effect in bus order, one per cycle: back-to-back set and clear writes to the same bit leave the value of the later one. A read that shares a cycle with a write to the same word returns the value held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write enable for the current access |
| bus_addr | input | ADDR_W | Byte address of the current access |
| bus_wdata | input | 32 | Write data |
| rd_data | output | 32 | Registered read data for the address of the previous cycle |
| pin_in | input | NUM_PINS | Asynchronous pin levels |
| pin_out | output | NUM_PINS | Output latch value per pin |
| pin_oe | output | NUM_PINS | Output enable per pin (1 = driven) |

## Verification
Two things can happen in the same cycle: a bus read of a word and a bus write to that same word. The write updates the register at the clock edge where the read data is captured. The bench provokes this with a combined access and expects the value from before the write, and a following plain read must show the new value. A second overlap is a pin change racing a read of the input word. The bench changes the pins and reads immediately, then again two cycles later, and expects the old level first and the new level after that.

// File: rtl/gpio_pkg.sv
`timescale 1ns/1ps
package gpio_pkg;
  localparam int unsigned WORD_W        = 32;
  localparam int unsigned REGS_PER_BANK = 5;
  localparam int unsigned BANK_SPAN     = REGS_PER_BANK * 4;

  typedef enum logic [2:0] {
    REG_DIR = 3'd0,
    REG_OUT = 3'd1,
    REG_SET = 3'd2,
    REG_CLR = 3'd3,
    REG_IN  = 3'd4
  } reg_kind_e;
endpackage

// File: rtl/gpio_sync.sv
`timescale 1ns/1ps
module gpio_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1   <= '0;
      sync_out <= '0;
    end else begin
      stage1   <= async_in;
      sync_out <= stage1;
    end
  end
endmodule

// File: rtl/gpio_addr_dec.sv
`timescale 1ns/1ps
module gpio_addr_dec
  import gpio_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned NUM_BANKS = 5,
  parameter int unsigned BASE      = 'h10,
  parameter int unsigned STRIDE    = 'h28
) (
  input  logic [ADDR_W-1:0]    addr,
  output logic [NUM_BANKS-1:0] bank_hit,
  output reg_kind_e            kind
);
  int unsigned lo;
  int unsigned rel;
  int unsigned a;

  always_comb begin
    bank_hit = '0;
    kind     = REG_DIR;
    a        = 32'(addr);
    lo       = 0;
    rel      = 0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      lo  = BASE + b * STRIDE;
      rel = a - lo;
      if (a >= lo && rel < BANK_SPAN && rel[1:0] == 2'b00) begin
        bank_hit[b] = 1'b1;
        kind        = reg_kind_e'(rel[4:2]);
      end
    end
  end
endmodule

// File: rtl/gpio_bank.sv
`timescale 1ns/1ps
module gpio_bank
  import gpio_pkg::*;
#(
  parameter int unsigned BW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  reg_kind_e     kind,
  input  logic [BW-1:0] wdata,
  input  logic [BW-1:0] lvl_in,
  output logic [BW-1:0] dir_q,
  output logic [BW-1:0] out_q,
  output logic [WORD_W-1:0] rdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= '1;
      out_q <= '0;
    end else if (wr_en) begin
      case (kind)
        REG_DIR: dir_q <= wdata;
        REG_OUT: out_q <= wdata;
        REG_SET: out_q <= out_q | wdata;
        REG_CLR: out_q <= out_q & ~wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    case (kind)
      REG_DIR:                   rdata[BW-1:0] = dir_q;
      REG_OUT, REG_SET, REG_CLR: rdata[BW-1:0] = out_q;
      REG_IN:                    rdata[BW-1:0] = lvl_in;
      default:                   rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_banked.sv
`timescale 1ns/1ps
module gpio_banked
  import gpio_pkg::*;
#(
  parameter int unsigned NUM_PINS = 144,
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned BASE     = 'h10,
  parameter int unsigned STRIDE   = 'h28
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_we,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [WORD_W-1:0]   bus_wdata,
  output logic [WORD_W-1:0]   rd_data,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe
);
  localparam int unsigned NUM_BANKS = (NUM_PINS + WORD_W - 1) / WORD_W;

  logic [NUM_BANKS-1:0] bank_hit;
  reg_kind_e            kind;
  logic [NUM_PINS-1:0]  pin_sync;
  logic [NUM_PINS-1:0]  dir_all;
  logic [WORD_W-1:0]    bank_rd [NUM_BANKS];
  logic [WORD_W-1:0]    rd_next;

  gpio_addr_dec #(
    .ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS), .BASE(BASE), .STRIDE(STRIDE)
  ) u_dec (
    .addr(bus_addr), .bank_hit(bank_hit), .kind(kind)
  );

  gpio_sync #(.W(NUM_PINS)) u_sync (
    .clk(clk), .rst(rst), .async_in(pin_in), .sync_out(pin_sync)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int unsigned LO = b * WORD_W;
    localparam int unsigned BW = (NUM_PINS - LO > WORD_W) ? WORD_W : NUM_PINS - LO;

    gpio_bank #(.BW(BW)) u_bank (
      .clk   (clk),
      .rst   (rst),
      .wr_en (bus_we & bank_hit[b]),
      .kind  (kind),
      .wdata (bus_wdata[BW-1:0]),
      .lvl_in(pin_sync[LO +: BW]),
      .dir_q (dir_all[LO +: BW]),
      .out_q (pin_out[LO +: BW]),
      .rdata (bank_rd[b])
    );
  end

  assign pin_oe = ~dir_all;

  always_comb begin
    rd_next = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bank_hit[b]) rd_next = rd_next | bank_rd[b];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_next;
  end
endmodule

// File: rtl/gpio_banked_chk.sv
`timescale 1ns/1ps
module gpio_banked_chk #(
  parameter int unsigned NUM_PINS = 144,
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned BASE     = 'h10
) (
  input logic                clk,
  input logic                rst,
  input logic                bus_we,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [31:0]         bus_wdata,
  input logic [31:0]         rd_data,
  input logic [NUM_PINS-1:0] pin_out,
  input logic [NUM_PINS-1:0] pin_oe
);
  localparam logic [ADDR_W-1:0] A_DIR0 = ADDR_W'(BASE);
  localparam logic [ADDR_W-1:0] A_SET0 = ADDR_W'(BASE + 8);
  localparam logic [ADDR_W-1:0] A_CLR0 = ADDR_W'(BASE + 12);

  AST_SET_RAISES: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == A_SET0) |=>
      ((pin_out[31:0] & $past(bus_wdata)) == $past(bus_wdata))); // R5

  AST_CLR_LOWERS: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == A_CLR0) |=>
      ((pin_out[31:0] & $past(bus_wdata)) == 32'd0)); // R6

  AST_DIR_TO_OE: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == A_DIR0) |=> (pin_oe[31:0] == ~$past(bus_wdata))); // R3

  AST_LOW_ADDR_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_addr < A_DIR0) |=> (rd_data == 32'd0)); // R9

  AST_IDLE_HOLDS_PINS: assert property (@(posedge clk) disable iff (rst)
    (!bus_we || bus_addr < A_DIR0) |=> ($stable(pin_out) && $stable(pin_oe))); // R9

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (pin_oe == '0 && pin_out == '0 && rd_data == 32'd0)); // R1
endmodule

bind gpio_banked gpio_banked_chk #(
  .NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .BASE(BASE)
) u_chk (
  .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .rd_data(rd_data), .pin_out(pin_out), .pin_oe(pin_oe)
);

// File: tb/gpio_banked_bench.sv
`timescale 1ns/1ps
module gpio_banked_bench;
  localparam int NP = 144;
  localparam int NB = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_we = 1'b0;
  logic [7:0]    bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   rd_data;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_out;
  logic [NP-1:0] pin_oe;

  int total = 0;
  int fails = 0;

  logic [31:0] dir_m [NB];
  logic [31:0] out_m [NB];

  always #10 clk = ~clk;

  gpio_banked u_gpio_banked (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .rd_data(rd_data), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  function automatic logic [7:0] wa(int b, int k);
    return 8'(16 + 40 * b + 4 * k);
  endfunction

  function automatic logic [31:0] bmask(int b);
    int n = NP - 32 * b;
    if (n >= 32) return 32'hFFFF_FFFF;
    return (32'd1 << n) - 32'd1;
  endfunction

  function automatic logic [NP-1:0] exp_oe();
    logic [NP-1:0] v = '0;
    for (int b = 0; b < NB; b++)
      for (int i = 0; i < 32; i++)
        if (32 * b + i < NP) v[32 * b + i] = ~dir_m[b][i];
    return v;
  endfunction

  function automatic logic [NP-1:0] exp_out();
    logic [NP-1:0] v = '0;
    for (int b = 0; b < NB; b++)
      for (int i = 0; i < 32; i++)
        if (32 * b + i < NP) v[32 * b + i] = out_m[b][i];
    return v;
  endfunction

  function automatic logic [31:0] exp_rd(int b, int k);
    logic [31:0] p = '0;
    for (int i = 0; i < 32; i++)
      if (32 * b + i < NP) p[i] = pin_in[32 * b + i];
    case (k)
      0:       return dir_m[b] & bmask(b);
      1, 2, 3: return out_m[b] & bmask(b);
      default: return p;
    endcase
  endfunction

  task automatic model_wr(int b, int k, logic [31:0] d);
    case (k)
      0: dir_m[b] = d & bmask(b);
      1: out_m[b] = d & bmask(b);
      2: out_m[b] = (out_m[b] | d) & bmask(b);
      3: out_m[b] = out_m[b] & ~d;
      default: ;
    endcase
  endtask

  task automatic chk(string req, logic [NP-1:0] act, logic [NP-1:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] q);
    bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    q = rd_data;
  endtask

  task automatic wr_rd(logic [7:0] a, logic [31:0] d, output logic [31:0] q);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    q = rd_data;
    bus_we = 1'b0;
  endtask

  initial begin
    #4_000_000;
    total++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [31:0] q;
    logic [NP-1:0] pv;
    void'($urandom(32'd20240517));
    for (int b = 0; b < NB; b++) begin dir_m[b] = bmask(b); out_m[b] = '0; end
    repeat (3) @(negedge clk);
    chk("R1 oe in reset", pin_oe, '0);
    rst = 1'b0;
    chk("R1 rd_data after reset", {{(NP-32){1'b0}}, rd_data}, '0);
    chk("R1 out after reset", pin_out, '0);
    rd(wa(0, 0), q); chk("R1 dir reset bank0", NP'(q), NP'(32'hFFFF_FFFF));
    rd(wa(4, 0), q); chk("R10 dir reset partial bank", NP'(q), NP'(32'h0000_FFFF));

    // R2 / R3: direction per bank reaches correct pin slice
    wr(wa(2, 0), 32'h0F0F_00FF); model_wr(2, 0, 32'h0F0F_00FF);
    chk("R3 oe after dir write", pin_oe, exp_oe());
    rd(wa(2, 0), q); chk("R2 dir readback bank2", NP'(q), NP'(32'h0F0F_00FF));

    // R4 whole-latch write, independent of direction
    wr(wa(1, 1), 32'hDEAD_BEEF); model_wr(1, 1, 32'hDEAD_BEEF);
    chk("R4 out latch load", pin_out, exp_out());

    // R5 / R6 / R7
    wr(wa(1, 2), 32'h0000_0010); model_wr(1, 2, 32'h0000_0010);
    chk("R5 set port", pin_out, exp_out());
    wr(wa(1, 3), 32'h8000_0001); model_wr(1, 3, 32'h8000_0001);
    chk("R6 clear port", pin_out, exp_out());
    rd(wa(1, 2), q); chk("R7 set port reads latch", NP'(q), NP'(out_m[1]));
    rd(wa(1, 3), q); chk("R7 clear port reads latch", NP'(q), NP'(out_m[1]));

    // R11 ordering of back-to-back writes
    wr(wa(0, 2), 32'h0000_0100); wr(wa(0, 3), 32'h0000_0100);
    model_wr(0, 2, 32'h100); model_wr(0, 3, 32'h100);
    chk("R11 set then clear", pin_out, exp_out());
    wr(wa(0, 3), 32'h0000_0200); wr(wa(0, 2), 32'h0000_0200);
    model_wr(0, 3, 32'h200); model_wr(0, 2, 32'h200);
    chk("R11 clear then set", pin_out, exp_out());
    wr_rd(wa(3, 1), 32'h1234_5678, q);
    chk("R11 read during write sees old", NP'(q), NP'(out_m[3]));
    model_wr(3, 1, 32'h1234_5678);
    rd(wa(3, 1), q); chk("R11 read after write sees new", NP'(q), NP'(32'h1234_5678));

    // R9 unmapped and input-word writes ignored
    pv = pin_out;
    wr(8'h24, 32'hFFFF_FFFF); wr(8'h11, 32'hFFFF_FFFF); wr(8'hC4, 32'hFFFF_FFFF);
    wr(8'h00, 32'hFFFF_FFFF); wr(wa(1, 4), 32'hFFFF_FFFF);
    chk("R9 unmapped writes leave out", pin_out, pv);
    chk("R9 unmapped writes leave oe", pin_oe, exp_oe());
    rd(8'h24, q); chk("R9 gap read zero", NP'(q), '0);
    rd(8'h13, q); chk("R9 unaligned read zero", NP'(q), '0);
    rd(8'hC4, q); chk("R9 past-end read zero", NP'(q), '0);

    // R10 partial bank
    wr(wa(4, 1), 32'hFFFF_FFFF); model_wr(4, 1, 32'hFFFF_FFFF);
    rd(wa(4, 1), q); chk("R10 partial bank latch", NP'(q), NP'(32'h0000_FFFF));
    chk("R10 partial bank pins", pin_out, exp_out());

    // R8 synchronizer latency and output readback
    pin_in = '0; repeat (3) @(negedge clk);
    pin_in[40 +: 4] = 4'hA;
    rd(wa(1, 4), q); chk("R8 immediate read old", NP'(q), '0);
    rd(wa(1, 4), q);
    rd(wa(1, 4), q); chk("R8 read after sync new", NP'(q), NP'(exp_rd(1, 4)));

    // random mix
    for (int n = 0; n < 400; n++) begin
      int b = int'($urandom_range(NB - 1));
      int k = int'($urandom_range(4));
      logic [31:0] d = $urandom;
      if ($urandom_range(15) == 0) begin
        pin_in = {$urandom, $urandom, $urandom, $urandom, $urandom};
        repeat (3) @(negedge clk);
      end
      wr(wa(b, k), d); model_wr(b, k, d);
      if (n % 8 == 0) begin
        chk("R3 random oe", pin_oe, exp_oe());
        chk("R4 random out", pin_out, exp_out());
      end
      b = int'($urandom_range(NB - 1));
      k = int'($urandom_range(4));
      rd(wa(b, k), q);
      chk("R2 random readback", NP'(q), NP'(exp_rd(b, k)));
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule